// File: doc/BRIEF.md
# Watchdog timer with reset grace window

This block is a watchdog for a system that talks to it over a simple synchronous register bus. A free-running up counter runs on a slow, separate watchdog clock. When the counter reaches a selectable power-of-two interval, the block raises a time-out flag and opens a grace window of selectable length. Software may restart the counter inside that window by writing a fixed key word. If the window closes without that write, the block asks for a system reset.

Control changes cross into the watchdog clock domain through two-flop synchronisers. A busy bit shows when an enable change has not yet arrived there. Every configuration field is write-protected by an unlock input. The block also has sticky time-out, reset and wake flags, a wake request, and a debug-halt input that can freeze the count.

Top module: `wdog_win`

## Requirements
- R1: Interval field bits [11:8] of the control register (offset 0x0): code n from 0 to 8 gives a time-out after 2^(4+2n) counted watchdog clock edges. Counting starts on the third watchdog edge after the enabling write. The time-out flag can be read three bus edges after the watchdog edge on which the time-out happens.
- R2: Time-out flag is control bit 3. It is set by a time-out and cleared by writing 1 to it. irq_o is high exactly while this flag and interrupt enable (bit 6) are both 1.
- R3: Window length field bits [1:0] at offset 0x4: 00 gives 1026, 01 gives 130, 10 gives 18 and 11 gives 3 watchdog clocks. If the window ends with reset enable (bit 1) set, rst_req_o pulses for exactly one bus cycle. If reset enable is clear, there is no pulse and counting restarts from zero.
- R4: Writing 0x00005AA5 to offset 0x8 clears the counter and closes the window. Any other value written there has no effect. Offset 0x8 reads as 0.
- R5: Enable is control bit 7. Clearing it stops the counter and zeroes it, so a later enable times out after the full interval. Enable changes and key writes take effect two watchdog clocks after the write.
- R6: Control bit 30 is read-only. It reads 1 right after an enable change and 0 once the change has taken effect.
- R7: Reset flag is control bit 2. A reset request sets it, and writing 1 clears it. A reset request also returns the window field to 00.
- R8: If wake enable (bit 4) and interrupt enable (bit 6) are both set at a time-out, wake flag bit 5 is set. wake_o follows that flag. Writing 1 to bit 5 clears it.
- R9: With control bit 31 at 0, the counter holds while dbg_halt_i is high. With bit 31 at 1, the counter runs regardless of dbg_halt_i.
- R10: When unlock_i is low, writes are ignored for bits 1, 4, 5, 6, 7, [11:8] and 31 of the control register and for the window field. Clearing bits 2 and 3 does not need unlock_i.
- R11: After reset, all registers read 0 and irq_o, wake_o and rst_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| wclk_i | input | 1 | Watchdog counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| unlock_i | input | 1 | High permits writes to protected fields |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Time-out interrupt |
| wake_o | output | 1 | Wake-up request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The counter-bound and halt assertions assume that the interval field and the debug bit change only while the watchdog is disabled and the disable has settled. They also assume that dbg_halt_i is quasi-static with respect to the watchdog clock. The bench keeps within these limits: it disables the watchdog and waits eight watchdog clocks before every reconfiguration, and it changes the halt input only while the watchdog is stopped. The watchdog clock has a fixed four-to-one ratio and a fixed phase offset against the bus clock. Every cross-domain latency is therefore deterministic, and the bench can check exact time-out and reset edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SEL_MAX  = 8;
  localparam int unsigned BASE_LOG = 4;
  localparam int unsigned STEP_LOG = 2;
  localparam int unsigned CNT_W    = BASE_LOG + STEP_LOG * SEL_MAX;
  localparam int unsigned DLY_W    = 11;
  localparam int unsigned SYNC_N   = 2;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_5AA5;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_DLY  = 4'h4;
  localparam logic [ADDR_W-1:0] A_KICK = 4'h8;

  localparam int unsigned B_RSTEN = 1;
  localparam int unsigned B_RSTF  = 2;
  localparam int unsigned B_TOF   = 3;
  localparam int unsigned B_WKEN  = 4;
  localparam int unsigned B_WKF   = 5;
  localparam int unsigned B_INTEN = 6;
  localparam int unsigned B_EN    = 7;
  localparam int unsigned B_SEL   = 8;
  localparam int unsigned B_BUSY  = 30;
  localparam int unsigned B_DBG   = 31;

  typedef enum logic {ST_RUN, ST_WIN} wd_st_e;

  // fields that cross into the watchdog clock domain
  typedef struct packed {
    logic             run_dbg;
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             rsten;
    logic [1:0]       dsel;
  } wd_wcfg_t;

  typedef struct packed {
    logic to_flag;
    logic rst_flag;
    logic wake_flag;
  } wd_stat_t;

  // codes above SEL_MAX behave as SEL_MAX
  function automatic logic [CNT_W-1:0] tout_last(input logic [SEL_W-1:0] sel);
    int unsigned s;
    logic [CNT_W:0] span;
    s = (32'(sel) > SEL_MAX) ? SEL_MAX : 32'(sel);
    span = (CNT_W+1)'(1) << (BASE_LOG + STEP_LOG * s);
    return CNT_W'(span - (CNT_W+1)'(1));
  endfunction

  function automatic logic [DLY_W-1:0] dly_last(input logic [1:0] dsel);
    case (dsel)
      2'd0:    return DLY_W'(1025);
      2'd1:    return DLY_W'(129);
      2'd2:    return DLY_W'(17);
      default: return DLY_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  wd_wcfg_t         cfg_i,
  input  logic             halt_i,
  input  logic             kick_tog_i,
  output logic             to_tog_o,
  output logic             rst_tog_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             kick_o
);
  wd_st_e           st_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             kick_d;
  logic             step;

  assign kick_o = kick_tog_i ^ kick_d;
  assign step   = !(halt_i && !cfg_i.run_dbg);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      cnt_o     <= '0;
      dcnt_q    <= '0;
      kick_d    <= 1'b0;
      to_tog_o  <= 1'b0;
      rst_tog_o <= 1'b0;
    end else begin
      kick_d <= kick_tog_i;
      if (!cfg_i.en || kick_o) begin
        cnt_o  <= '0;
        dcnt_q <= '0;
        st_q   <= ST_RUN;
      end else if (step) begin
        if (st_q == ST_RUN) begin
          if (cnt_o == tout_last(cfg_i.sel)) begin
            to_tog_o <= ~to_tog_o;
            st_q     <= ST_WIN;
            dcnt_q   <= '0;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end else begin
          if (dcnt_q == dly_last(cfg_i.dsel)) begin
            rst_tog_o <= rst_tog_o ^ cfg_i.rsten;
            st_q      <= ST_RUN;
            cnt_o     <= '0;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              unlock_i,
  input  logic              to_tog_i,
  input  logic              rst_tog_i,
  input  logic              en_ack_i,
  output wd_wcfg_t          wcfg_o,
  output wd_stat_t          stat_o,
  output logic              kick_tog_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              rst_req_o
);
  logic wr_ctrl, wr_dly, wr_kick;
  logic to_d, rst_d, to_p, rst_p;
  logic wken_q, inten_q;

  assign wr_ctrl = req_i && we_i && (addr_i == A_CTRL);
  assign wr_dly  = req_i && we_i && (addr_i == A_DLY);
  assign wr_kick = req_i && we_i && (addr_i == A_KICK);
  assign to_p    = to_tog_i ^ to_d;
  assign rst_p   = rst_tog_i ^ rst_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcfg_o     <= '0;
      stat_o     <= '0;
      wken_q     <= 1'b0;
      inten_q    <= 1'b0;
      kick_tog_o <= 1'b0;
      to_d       <= 1'b0;
      rst_d      <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      to_d      <= to_tog_i;
      rst_d     <= rst_tog_i;
      rst_req_o <= rst_p;
      if (wr_ctrl && unlock_i) begin
        wcfg_o.rsten   <= wdata_i[B_RSTEN];
        wken_q         <= wdata_i[B_WKEN];
        inten_q        <= wdata_i[B_INTEN];
        wcfg_o.en      <= wdata_i[B_EN];
        wcfg_o.sel     <= wdata_i[B_SEL +: SEL_W];
        wcfg_o.run_dbg <= wdata_i[B_DBG];
      end
      if (rst_p) wcfg_o.dsel <= 2'b00;
      else if (wr_dly && unlock_i) wcfg_o.dsel <= wdata_i[1:0];
      // set wins over a simultaneous write-one clear
      stat_o.to_flag   <= to_p || (stat_o.to_flag && !(wr_ctrl && wdata_i[B_TOF]));
      stat_o.rst_flag  <= rst_p || (stat_o.rst_flag && !(wr_ctrl && wdata_i[B_RSTF]));
      stat_o.wake_flag <= (to_p && wken_q && inten_q) ||
                          (stat_o.wake_flag && !(wr_ctrl && unlock_i && wdata_i[B_WKF]));
      if (wr_kick && (wdata_i == KICK_KEY)) kick_tog_o <= ~kick_tog_o;
    end
  end

  assign irq_o  = stat_o.to_flag && inten_q;
  assign wake_o = stat_o.wake_flag;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_RSTEN]           = wcfg_o.rsten;
        rdata_o[B_RSTF]            = stat_o.rst_flag;
        rdata_o[B_TOF]             = stat_o.to_flag;
        rdata_o[B_WKEN]            = wken_q;
        rdata_o[B_WKF]             = stat_o.wake_flag;
        rdata_o[B_INTEN]           = inten_q;
        rdata_o[B_EN]              = wcfg_o.en;
        rdata_o[B_SEL +: SEL_W]    = wcfg_o.sel;
        rdata_o[B_BUSY]            = wcfg_o.en ^ en_ack_i;
        rdata_o[B_DBG]             = wcfg_o.run_dbg;
      end
      A_DLY:   rdata_o[1:0] = wcfg_o.dsel;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              unlock_i,
  input  logic              dbg_halt_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              rst_req_o
);
  wd_wcfg_t         wcfg_q, wcfg_s;
  wd_stat_t         stat_q;
  logic             kick_tog, kick_tog_s, halt_s;
  logic             to_tog, rst_tog, kick_p;
  logic [2:0]       back_s;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .unlock_i   (unlock_i),
    .to_tog_i   (back_s[2]),
    .rst_tog_i  (back_s[1]),
    .en_ack_i   (back_s[0]),
    .wcfg_o     (wcfg_q),
    .stat_o     (stat_q),
    .kick_tog_o (kick_tog),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o),
    .rst_req_o  (rst_req_o)
  );

  wdog_sync #(.W($bits(wd_wcfg_t)), .STAGES(SYNC_N)) u_sync_cfg (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (wcfg_q), .q_o (wcfg_s)
  );

  wdog_sync #(.W(2), .STAGES(SYNC_N)) u_sync_in (
    .clk_i (wclk_i), .rst_ni (rst_ni),
    .d_i ({kick_tog, dbg_halt_i}), .q_o ({kick_tog_s, halt_s})
  );

  wdog_sync #(.W(3), .STAGES(SYNC_N)) u_sync_back (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i ({to_tog, rst_tog, wcfg_s.en}), .q_o (back_s)
  );

  wdog_core u_core (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (wcfg_s),
    .halt_i     (halt_s),
    .kick_tog_i (kick_tog_s),
    .to_tog_o   (to_tog),
    .rst_tog_o  (rst_tog),
    .cnt_o      (cnt),
    .kick_o     (kick_p)
  );
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk
  import wdog_pkg::*;
(
  input logic              clk_i,
  input logic              wclk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              unlock_i,
  input logic              rst_req_o,
  input logic              b_en,
  input logic [SEL_W-1:0]  b_sel,
  input logic [1:0]        b_dsel,
  input logic              to_flag,
  input logic              rst_flag,
  input logic              wake_flag,
  input logic              s_en,
  input logic [SEL_W-1:0]  s_sel,
  input logic              s_dbg,
  input logic              halt_s,
  input logic              kick_p,
  input logic [CNT_W-1:0]  cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (s_en && $past(s_en) && $stable(s_sel)) |-> (cnt <= tout_last(s_sel))) else $error("cnt past interval"); // R1
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o) else $error("reset request wider than one cycle"); // R3
  AST_KICK_CLEAR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (kick_p && s_en) |=> (cnt == '0)) else $error("key write did not clear counter"); // R4
  AST_RST_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_flag && (b_dsel == 2'b00))) else $error("reset flag or window field wrong"); // R7
  AST_WAKE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_flag) |-> to_flag) else $error("wake without time-out"); // R8
  AST_HALT_HOLD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (s_en && halt_s && !s_dbg && !kick_p) |=> $stable(cnt)) else $error("counter moved in halt"); // R9
  AST_LOCKED_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i == A_CTRL) && !unlock_i) |=> ($stable(b_en) && $stable(b_sel))) else $error("locked write landed"); // R10
endmodule

bind wdog_win wdog_win_chk u_chk (
  .clk_i     (clk_i),
  .wclk_i    (wclk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .unlock_i  (unlock_i),
  .rst_req_o (rst_req_o),
  .b_en      (wcfg_q.en),
  .b_sel     (wcfg_q.sel),
  .b_dsel    (wcfg_q.dsel),
  .to_flag   (stat_q.to_flag),
  .rst_flag  (stat_q.rst_flag),
  .wake_flag (stat_q.wake_flag),
  .s_en      (wcfg_s.en),
  .s_sel     (wcfg_s.sel),
  .s_dbg     (wcfg_s.run_dbg),
  .halt_s    (halt_s),
  .kick_p    (kick_p),
  .cnt       (cnt)
);

// File: tb/sim_wdog_win.sv
`timescale 1ns/1ps
module sim_wdog_win;
  logic        clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, unlock = 1'b1, halt = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, wake, rst_req;

  int vectors = 0, fails = 0;
  int wcnt = 0, base = 0, rst_edges = 0, rst_hi = 0;
  logic rst_prev = 1'b0;

  wdog_win u0 (
    .clk_i(clk), .wclk_i(wclk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .unlock_i(unlock),
    .dbg_halt_i(halt), .irq_o(irq), .wake_o(wake), .rst_req_o(rst_req)
  );

  initial forever #10 clk = ~clk;               // 50 MHz
  initial begin #5; forever #40 wclk = ~wclk; end // quarter rate, offset phase

  always @(posedge wclk) wcnt++;
  always @(posedge clk) begin
    if (rst_req) rst_hi++;
    if (rst_req && !rst_prev) rst_edges++;
    rst_prev = rst_req;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 0;
  endtask

  function automatic logic [31:0] cw(bit en, int sel, bit inten, bit wken, bit rsten, bit dbg);
    return (32'(dbg) << 31) | (32'(sel) << 8) | (32'(en) << 7) | (32'(inten) << 6) |
           (32'(wken) << 4) | (32'(rsten) << 1);
  endfunction

  task automatic start(input logic [31:0] w);
    @(posedge wclk); bus_wr(4'h0, w); base = wcnt;
  endtask

  // kind 0: time-out flag; kind 1: reset pulse. first = watchdog edge index, -1 if none
  task automatic run_until(input int kind, input int limit, output int first);
    int r0;
    r0 = rst_edges; first = -1;
    while (wcnt - base < limit) begin
      @(posedge wclk); #70;
      if (first < 0) begin
        if (kind == 0 && rdata[3]) first = wcnt - base;
        if (kind == 1 && rst_edges != r0) first = wcnt - base;
      end
    end
  endtask

  task automatic cleanup();
    bus_wr(4'h0, 32'h2C);
    repeat (8) @(posedge wclk);
    bus_wr(4'h0, 32'h2C);
    bus_wr(4'h4, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f, h0, e0;
    int dly_tab[4];
    dly_tab = '{1026, 130, 18, 3};
    #100 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R11 reset state
    rd(4'h0, d); chk(d == 0, "R11 ctrl", d, 0);
    rd(4'h4, d); chk(d == 0, "R11 dly", d, 0);
    chk({irq, wake, rst_req} == 3'b0, "R11 outputs", {irq, wake, rst_req}, 0);

    // R10 locked writes
    unlock = 0;
    bus_wr(4'h0, cw(1, 3, 1, 1, 1, 1));
    bus_wr(4'h4, 32'h3);
    rd(4'h0, d); chk(d == 0, "R10 locked ctrl", d, 0);
    rd(4'h4, d); chk(d == 0, "R10 locked dly", d, 0);
    unlock = 1;

    // R6 busy
    bus_wr(4'h0, cw(1, 0, 0, 0, 0, 0));
    rd(4'h0, d); chk(d[30] == 1, "R6 busy after enable", d[30], 1);
    repeat (8) @(posedge wclk);
    rd(4'h0, d); chk(d[30] == 0, "R6 busy settled", d[30], 0);
    bus_wr(4'h0, 32'h0);
    rd(4'h0, d); chk(d[30] == 1, "R6 busy after disable", d[30], 1);
    repeat (8) @(posedge wclk);
    rd(4'h0, d); chk(d[30] == 0, "R6 busy settled off", d[30], 0);
    cleanup();

    // R1 interval sweep, R2 irq and clear
    for (int c = 0; c <= 4; c++) begin
      int t;
      t = 1 << (4 + 2 * c);
      cleanup();
      start(cw(1, c, 1, 0, 0, 0));
      run_until(0, t + 3, f);
      chk(f == t + 2, "R1 time-out edge", f, t + 2);
      chk(irq == 1, "R2 irq set", irq, 1);
    end
    bus_wr(4'h0, 32'h0);
    repeat (8) @(posedge wclk);
    bus_wr(4'h0, 32'h8);
    rd(4'h0, d); chk(d[3] == 0, "R2 flag cleared", d[3], 0);
    chk(irq == 0, "R2 irq cleared", irq, 0);

    // R3 window lengths, R7 reset flag and field return
    for (int k = 0; k < 4; k++) begin
      cleanup();
      bus_wr(4'h4, 32'(k));
      h0 = rst_hi;
      start(cw(1, 0, 0, 0, 1, 0));
      run_until(1, 18 + dly_tab[k] + 1, f);
      chk(f == 18 + dly_tab[k], "R3 reset edge", f, 18 + dly_tab[k]);
      chk(rst_hi - h0 == 1, "R3 pulse width", rst_hi - h0, 1);
      rd(4'h0, d); chk(d[2] == 1, "R7 reset flag", d[2], 1);
      rd(4'h4, d); chk(d == 0, "R7 window field back to 00", d, 0);
    end
    cleanup();
    rd(4'h0, d); chk(d[2] == 0, "R7 reset flag cleared", d[2], 0);

    // R3 no request without reset enable
    bus_wr(4'h4, 32'h3);
    start(cw(1, 0, 0, 0, 0, 0));
    run_until(1, 30, f);
    chk(f == -1, "R3 no reset when disabled", f, -1);
    rd(4'h0, d); chk(d[3] == 1, "R3 time-out still flagged", d[3], 1);
    cleanup();

    // R4 correct key inside the window
    bus_wr(4'h4, 32'h2);
    start(cw(1, 0, 0, 0, 1, 0));
    run_until(0, 18, f);
    bus_wr(4'h8, 32'h0000_5AA5);
    run_until(1, 40, f);
    chk(f == -1, "R4 key prevents reset", f, -1);
    rd(4'h8, d); chk(d == 0, "R4 key reg reads 0", d, 0);
    cleanup();

    // R4 wrong key ignored
    bus_wr(4'h4, 32'h2);
    start(cw(1, 0, 0, 0, 1, 0));
    e0 = rst_edges;
    run_until(0, 18, f);
    bus_wr(4'h8, 32'h0000_5AA4);
    run_until(1, 40, f);
    if (f < 0 && rst_edges != e0) f = 0;
    chk(f == 36, "R4 wrong key ignored", f, 36);
    cleanup();

    // R5 disable zeroes counter
    start(cw(1, 1, 0, 0, 0, 0));
    run_until(0, 40, f);
    chk(f == -1, "R5 no early time-out", f, -1);
    bus_wr(4'h0, 32'h0);
    repeat (8) @(posedge wclk);
    start(cw(1, 1, 0, 0, 0, 0));
    run_until(0, 68, f);
    chk(f == 66, "R5 full interval after re-enable", f, 66);
    cleanup();

    // R9 debug hold
    halt = 1;
    repeat (4) @(posedge wclk);
    start(cw(1, 0, 0, 0, 0, 0));
    run_until(0, 40, f);
    chk(f == -1, "R9 held by halt", f, -1);
    cleanup();
    start(cw(1, 0, 0, 0, 0, 1));
    run_until(0, 20, f);
    chk(f == 18, "R9 runs when debug bit set", f, 18);
    bus_wr(4'h0, 32'h0);
    halt = 0;
    cleanup();

    // R8 wake, R10 locked wake clear
    start(cw(1, 0, 1, 1, 0, 0));
    run_until(0, 20, f);
    chk(f == 18, "R8 time-out", f, 18);
    rd(4'h0, d); chk(d[5] == 1, "R8 wake flag", d[5], 1);
    chk(wake == 1, "R8 wake_o", wake, 1);
    unlock = 0;
    bus_wr(4'h0, cw(1, 0, 1, 1, 0, 0) | 32'h20);
    rd(4'h0, d); chk(d[5] == 1, "R10 locked wake clear", d[5], 1);
    unlock = 1;
    bus_wr(4'h0, cw(1, 0, 1, 1, 0, 0) | 32'h20);
    rd(4'h0, d); chk(d[5] == 0, "R8 wake clear", d[5], 0);
    chk(wake == 0, "R8 wake_o low", wake, 0);
    cleanup();
    start(cw(1, 0, 0, 1, 0, 0));
    run_until(0, 20, f);
    rd(4'h0, d);
    chk(d[5] == 0 && wake == 0, "R8 no wake without irq enable", d[5], 0);
    chk(irq == 0 && d[3] == 1, "R2 irq gated by enable", irq, 0);
    cleanup();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule